// File: doc/BRIEF.md
# Serial EEPROM Descriptor Override Loader

After reset this block fetches a short configuration record from an external serial EEPROM through an I2C master command port. It writes the device write address and word address 0, issues a repeated start, sends the device read address, and reads the whole record sequentially. The last byte of the record is a signature. Only when the signature matches, and every address phase was acknowledged, do the stored vendor ID, product ID, configuration attributes and maximum power values replace the built-in defaults. In every other case the defaults stay in force.

The block drives command-level requests (start, write byte, read byte with ACK or NACK, stop) and leaves bit timing to a separate I2C master. The four effective descriptor values go to a downstream descriptor engine. That engine waits for the done flag and reads the loaded flag to learn whether the override was taken. Captured bytes sit in shadow registers, so the four outputs change together, in the cycle the load completes.

Top module: `desc_override_loader`

## Requirements
- R1: While reset is asserted, load_done and load_ok are 0, cmd_valid is 0, and the four value outputs equal the DEF_VID, DEF_PID, DEF_ATTR and DEF_PWR parameters.
- R2: With every address phase acknowledged, exactly 14 commands are issued in this order: START, WRITE DEV_ADDR (default 0xA0), WRITE 0x00, START, WRITE DEV_ADDR|1 (0xA1), eight READs, STOP. cmd_op codes are START=0, WRITE=1, READ=2, STOP=3.
- R3: cmd_rd_nack is 0 (ACK) for the first seven READ commands and 1 (NACK) for the eighth.
- R4: After a valid load, vendor_id = {byte1, byte0}, product_id = {byte3, byte2}, cfg_attr = byte4 and max_power = byte5. Byte 6 has no effect on any output.
- R5: load_ok goes to 1 and the stored values are applied only when byte 7 equals SIG (default 0x58). For any other byte 7 value, load_ok stays 0 and all four outputs stay at their defaults.
- R6: If a WRITE response reports no acknowledge (rsp_ack=0) for the device write address, the word address or the device read address, the block issues STOP and then no further command. It finishes with load_ok=0 and default outputs.
- R7: Before load_done is 1, every output holds its default and load_ok is 0. Once load_done is 1, the outputs no longer change.
- R8: load_done rises exactly once after reset and stays high. No command is issued after it rises.
- R9: A command is held on cmd_valid, with stable op, data and nack bit, until cmd_ready. After acceptance, cmd_valid drops, and the next command follows only after rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | output | 1 | Command request to the I2C master |
| cmd_ready | input | 1 | Master accepts the command this cycle |
| cmd_op | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_wdata | output | 8 | Byte for WRITE commands |
| cmd_rd_nack | output | 1 | For READ: 1 sends NACK after the byte, 0 sends ACK |
| rsp_valid | input | 1 | One-cycle completion of the outstanding command |
| rsp_ack | input | 1 | For WRITE: 1 if the device acknowledged |
| rsp_rdata | input | 8 | For READ: the byte received |
| vendor_id | output | 16 | Effective vendor ID |
| product_id | output | 16 | Effective product ID |
| cfg_attr | output | 8 | Effective configuration attributes byte |
| max_power | output | 8 | Effective maximum power byte |
| load_done | output | 1 | Loading finished (sticky) |
| load_ok | output | 1 | 1 if the EEPROM values were applied, 0 if ignored |

## Verification
The assertions check the following on every cycle:
- Command holding and the single outstanding command rule.
- The sticky done flag and the silence after it.
- Defaults before done, and outputs frozen after done.
- Defaults whenever the override was rejected.

Some behaviour depends on the EEPROM's contents and responses, and only the bench's scenarios can show it:
- The exact command order and addresses, and the ACK/NACK pattern on reads.
- The byte-to-field mapping.
- Acceptance of the one signature value out of all 256.
- The abort path at each of the three address phases.

// File: rtl/dol_pkg.sv
package dol_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } i2c_op_e;

    typedef enum logic [3:0] {
        S_BOOT,
        S_START1,
        S_DEVW,
        S_WADDR,
        S_START2,
        S_DEVR,
        S_READ,
        S_STOP,
        S_DONE
    } seq_st_e;

    // record field offsets (the signature offset is REC_LEN-1)
    localparam int OFS_VID_LO = 0;
    localparam int OFS_VID_HI = 1;
    localparam int OFS_PID_LO = 2;
    localparam int OFS_PID_HI = 3;
    localparam int OFS_ATTR   = 4;
    localparam int OFS_PWR    = 5;

endpackage

// File: rtl/dol_seq.sv
module dol_seq
    import dol_pkg::*;
#(
    parameter int         REC_LEN  = 8,
    parameter logic [7:0] DEV_ADDR = 8'hA0,
    parameter logic [7:0] WORD0    = 8'h00
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_ready,
    input  logic                       rsp_valid,
    input  logic                       rsp_ack,
    output logic                       cmd_valid,
    output i2c_op_e                    cmd_op,
    output logic [7:0]                 cmd_wdata,
    output logic                       cmd_rd_nack,
    output logic                       cap_en,
    output logic [$clog2(REC_LEN)-1:0] cap_idx,
    output logic                       fin,
    output logic                       fin_abort
);

    localparam int                IDXW = $clog2(REC_LEN);
    localparam logic [IDXW-1:0]   LAST = IDXW'(REC_LEN - 1);

    typedef struct packed {
        seq_st_e         st;
        logic            issued;
        logic            abort;
        logic [IDXW-1:0] idx;
    } seq_t;

    seq_t q, d;
    logic in_cmd;
    logic done_rsp;

    always_comb begin
        d           = q;
        cmd_op      = OP_START;
        cmd_wdata   = 8'h00;
        cmd_rd_nack = 1'b0;
        cap_en      = 1'b0;
        fin         = 1'b0;
        in_cmd      = (q.st != S_BOOT) && (q.st != S_DONE);

        case (q.st)
            S_START1, S_START2: cmd_op = OP_START;
            S_DEVW: begin
                cmd_op    = OP_WRITE;
                cmd_wdata = DEV_ADDR;
            end
            S_WADDR: begin
                cmd_op    = OP_WRITE;
                cmd_wdata = WORD0;
            end
            S_DEVR: begin
                cmd_op    = OP_WRITE;
                cmd_wdata = DEV_ADDR | 8'h01;
            end
            S_READ: begin
                cmd_op      = OP_READ;
                cmd_rd_nack = (q.idx == LAST);
            end
            S_STOP:  cmd_op = OP_STOP;
            default: cmd_op = OP_START;
        endcase

        cmd_valid = in_cmd && !q.issued;
        if (cmd_valid && cmd_ready) begin
            d.issued = 1'b1;
        end

        done_rsp = q.issued && rsp_valid;

        if (q.st == S_BOOT) begin
            d.st = S_START1;
        end else if (done_rsp) begin
            d.issued = 1'b0;
            case (q.st)
                S_START1: d.st = S_DEVW;
                S_DEVW: begin
                    if (rsp_ack) begin
                        d.st = S_WADDR;
                    end else begin
                        d.abort = 1'b1;
                        d.st    = S_STOP;
                    end
                end
                S_WADDR: begin
                    if (rsp_ack) begin
                        d.st = S_START2;
                    end else begin
                        d.abort = 1'b1;
                        d.st    = S_STOP;
                    end
                end
                S_START2: d.st = S_DEVR;
                S_DEVR: begin
                    if (rsp_ack) begin
                        d.st  = S_READ;
                        d.idx = '0;
                    end else begin
                        d.abort = 1'b1;
                        d.st    = S_STOP;
                    end
                end
                S_READ: begin
                    cap_en = 1'b1;
                    if (q.idx == LAST) begin
                        d.st = S_STOP;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                S_STOP: begin
                    fin  = 1'b1;
                    d.st = S_DONE;
                end
                default: d.st = q.st;
            endcase
        end

        cap_idx   = q.idx;
        fin_abort = q.abort;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= S_BOOT;
            q.issued <= 1'b0;
            q.abort  <= 1'b0;
            q.idx    <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/dol_shadow.sv
module dol_shadow #(
    parameter int REC_LEN = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cap_en,
    input  logic [$clog2(REC_LEN)-1:0]     cap_idx,
    input  logic [7:0]                     cap_data,
    output logic [REC_LEN-1:0][7:0]        rec
);

    localparam int IDXW = $clog2(REC_LEN);

    logic [REC_LEN-1:0][7:0] rec_d, rec_q;

    for (genvar i = 0; i < REC_LEN; i++) begin : g_byte
        always_comb begin
            rec_d[i] = rec_q[i];
            if (cap_en && (cap_idx == IDXW'(i))) begin
                rec_d[i] = cap_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end

    assign rec = rec_q;

endmodule

// File: rtl/dol_commit.sv
module dol_commit
    import dol_pkg::*;
#(
    parameter int          REC_LEN  = 8,
    parameter logic [7:0]  SIG      = 8'h58,
    parameter logic [15:0] DEF_VID  = 16'h1D6B,
    parameter logic [15:0] DEF_PID  = 16'h0104,
    parameter logic [7:0]  DEF_ATTR = 8'h80,
    parameter logic [7:0]  DEF_PWR  = 8'h32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fin,
    input  logic                    fin_abort,
    input  logic [REC_LEN-1:0][7:0] rec,
    output logic [15:0]             vendor_id,
    output logic [15:0]             product_id,
    output logic [7:0]              cfg_attr,
    output logic [7:0]              max_power,
    output logic                    load_done,
    output logic                    load_ok
);

    localparam int OFS_SIG = REC_LEN - 1;

    typedef struct packed {
        logic        done;
        logic        ok;
        logic [15:0] vid;
        logic [15:0] pid;
        logic [7:0]  attr;
        logic [7:0]  pwr;
    } out_t;

    out_t q, d;
    logic sig_match;

    always_comb begin
        d         = q;
        sig_match = (rec[OFS_SIG] == SIG);
        if (fin && !q.done) begin
            d.done = 1'b1;
            if (!fin_abort && sig_match) begin
                d.ok   = 1'b1;
                d.vid  = {rec[OFS_VID_HI], rec[OFS_VID_LO]};
                d.pid  = {rec[OFS_PID_HI], rec[OFS_PID_LO]};
                d.attr = rec[OFS_ATTR];
                d.pwr  = rec[OFS_PWR];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.done <= 1'b0;
            q.ok   <= 1'b0;
            q.vid  <= DEF_VID;
            q.pid  <= DEF_PID;
            q.attr <= DEF_ATTR;
            q.pwr  <= DEF_PWR;
        end else begin
            q <= d;
        end
    end

    assign vendor_id  = q.vid;
    assign product_id = q.pid;
    assign cfg_attr   = q.attr;
    assign max_power  = q.pwr;
    assign load_done  = q.done;
    assign load_ok    = q.ok;

endmodule

// File: rtl/desc_override_loader.sv
module desc_override_loader
    import dol_pkg::*;
#(
    parameter int          REC_LEN  = 8,
    parameter logic [7:0]  DEV_ADDR = 8'hA0,
    parameter logic [7:0]  SIG      = 8'h58,
    parameter logic [15:0] DEF_VID  = 16'h1D6B,
    parameter logic [15:0] DEF_PID  = 16'h0104,
    parameter logic [7:0]  DEF_ATTR = 8'h80,
    parameter logic [7:0]  DEF_PWR  = 8'h32
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        cmd_valid,
    input  logic        cmd_ready,
    output logic [1:0]  cmd_op,
    output logic [7:0]  cmd_wdata,
    output logic        cmd_rd_nack,
    input  logic        rsp_valid,
    input  logic        rsp_ack,
    input  logic [7:0]  rsp_rdata,
    output logic [15:0] vendor_id,
    output logic [15:0] product_id,
    output logic [7:0]  cfg_attr,
    output logic [7:0]  max_power,
    output logic        load_done,
    output logic        load_ok
);

    localparam int IDXW = $clog2(REC_LEN);

    i2c_op_e                 op_e;
    logic                    cap_en;
    logic [IDXW-1:0]         cap_idx;
    logic                    fin;
    logic                    fin_abort;
    logic [REC_LEN-1:0][7:0] rec;

    dol_seq #(
        .REC_LEN  (REC_LEN),
        .DEV_ADDR (DEV_ADDR),
        .WORD0    (8'h00)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_ready   (cmd_ready),
        .rsp_valid   (rsp_valid),
        .rsp_ack     (rsp_ack),
        .cmd_valid   (cmd_valid),
        .cmd_op      (op_e),
        .cmd_wdata   (cmd_wdata),
        .cmd_rd_nack (cmd_rd_nack),
        .cap_en      (cap_en),
        .cap_idx     (cap_idx),
        .fin         (fin),
        .fin_abort   (fin_abort)
    );

    assign cmd_op = op_e;

    dol_shadow #(
        .REC_LEN (REC_LEN)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_idx  (cap_idx),
        .cap_data (rsp_rdata),
        .rec      (rec)
    );

    dol_commit #(
        .REC_LEN  (REC_LEN),
        .SIG      (SIG),
        .DEF_VID  (DEF_VID),
        .DEF_PID  (DEF_PID),
        .DEF_ATTR (DEF_ATTR),
        .DEF_PWR  (DEF_PWR)
    ) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .fin        (fin),
        .fin_abort  (fin_abort),
        .rec        (rec),
        .vendor_id  (vendor_id),
        .product_id (product_id),
        .cfg_attr   (cfg_attr),
        .max_power  (max_power),
        .load_done  (load_done),
        .load_ok    (load_ok)
    );

endmodule

// File: rtl/dol_checker.sv
module dol_checker #(
    parameter logic [15:0] DEF_VID  = 16'h1D6B,
    parameter logic [15:0] DEF_PID  = 16'h0104,
    parameter logic [7:0]  DEF_ATTR = 8'h80,
    parameter logic [7:0]  DEF_PWR  = 8'h32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [1:0]  cmd_op,
    input logic [7:0]  cmd_wdata,
    input logic        cmd_rd_nack,
    input logic [15:0] vendor_id,
    input logic [15:0] product_id,
    input logic [7:0]  cfg_attr,
    input logic [7:0]  max_power,
    input logic        load_done,
    input logic        load_ok
);

    logic at_defaults;
    assign at_defaults = (vendor_id == DEF_VID) && (product_id == DEF_PID) &&
                         (cfg_attr == DEF_ATTR) && (max_power == DEF_PWR);

    assert_hold_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) &&
                                       $stable(cmd_wdata) && $stable(cmd_rd_nack)));

    assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_valid);

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done);

    assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !cmd_valid);

    assert_defaults_until_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_done |-> (at_defaults && !load_ok));

    assert_frozen_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> ($stable(vendor_id) && $stable(product_id) && $stable(cfg_attr) &&
                       $stable(max_power) && $stable(load_ok)));

    assert_fallback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && !load_ok) |-> at_defaults);

endmodule

bind desc_override_loader dol_checker #(
    .DEF_VID  (DEF_VID),
    .DEF_PID  (DEF_PID),
    .DEF_ATTR (DEF_ATTR),
    .DEF_PWR  (DEF_PWR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .cmd_wdata   (cmd_wdata),
    .cmd_rd_nack (cmd_rd_nack),
    .vendor_id   (vendor_id),
    .product_id  (product_id),
    .cfg_attr    (cfg_attr),
    .max_power   (max_power),
    .load_done   (load_done),
    .load_ok     (load_ok)
);

// File: tb/desc_override_loader_bench.sv
module desc_override_loader_bench;

    localparam logic [15:0] B_VID  = 16'hBEEF;
    localparam logic [15:0] B_PID  = 16'h0C1A;
    localparam logic [7:0]  B_ATTR = 8'hC0;
    localparam logic [7:0]  B_PWR  = 8'h19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid, cmd_ready, cmd_rd_nack;
    logic [1:0]  cmd_op;
    logic [7:0]  cmd_wdata;
    logic        rsp_valid = 1'b0, rsp_ack = 1'b0;
    logic [7:0]  rsp_rdata = 8'h00;
    logic [15:0] vendor_id, product_id;
    logic [7:0]  cfg_attr, max_power;
    logic        load_done, load_ok;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    desc_override_loader #(
        .DEF_VID  (B_VID),
        .DEF_PID  (B_PID),
        .DEF_ATTR (B_ATTR),
        .DEF_PWR  (B_PWR)
    ) u_desc_override_loader (
        .clk (clk), .rst_n (rst_n),
        .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_op (cmd_op),
        .cmd_wdata (cmd_wdata), .cmd_rd_nack (cmd_rd_nack),
        .rsp_valid (rsp_valid), .rsp_ack (rsp_ack), .rsp_rdata (rsp_rdata),
        .vendor_id (vendor_id), .product_id (product_id),
        .cfg_attr (cfg_attr), .max_power (max_power),
        .load_done (load_done), .load_ok (load_ok)
    );

    // EEPROM model at command level
    logic [7:0] mem [0:7];
    bit         present = 1'b1;
    int         nack_sel = 0;   // 1 dev-write, 2 word addr, 3 dev-read
    logic       busy = 1'b0;
    int         dly = 0;
    logic       pend_ack = 1'b0;
    logic [7:0] pend_data = 8'h00;
    logic [7:0] ptr = 8'h00;
    logic       phase = 1'b0;
    logic       rdmode = 1'b0;
    int         nlog = 0;
    logic [1:0] lg_op  [0:31];
    logic [7:0] lg_dat [0:31];
    logic       lg_nk  [0:31];

    assign cmd_ready = !busy;

    always @(posedge clk) begin
        rsp_valid <= 1'b0;
        if (!rst_n) begin
            busy <= 1'b0;
            nlog <= 0;
        end else if (busy) begin
            if (dly == 0) begin
                rsp_valid <= 1'b1;
                rsp_ack   <= pend_ack;
                rsp_rdata <= pend_data;
                busy      <= 1'b0;
            end else begin
                dly <= dly - 1;
            end
        end else if (cmd_valid) begin
            busy <= 1'b1;
            dly  <= nlog % 3;
            if (nlog < 32) begin
                lg_op[nlog]  <= cmd_op;
                lg_dat[nlog] <= cmd_wdata;
                lg_nk[nlog]  <= cmd_rd_nack;
            end
            nlog      <= nlog + 1;
            pend_ack  <= 1'b0;
            pend_data <= 8'hFF;
            case (cmd_op)
                2'd0: phase <= 1'b0;
                2'd1: begin
                    if (!phase) begin
                        phase <= 1'b1;
                        if (cmd_wdata == 8'hA0) begin
                            rdmode   <= 1'b0;
                            pend_ack <= present && (nack_sel != 1);
                        end else if (cmd_wdata == 8'hA1) begin
                            rdmode   <= 1'b1;
                            pend_ack <= present && (nack_sel != 3);
                        end
                    end else if (!rdmode) begin
                        ptr      <= cmd_wdata;
                        pend_ack <= present && (nack_sel != 2);
                    end
                end
                2'd2: begin
                    pend_data <= mem[ptr[2:0]];
                    ptr       <= ptr + 8'd1;
                end
                default: phase <= 1'b0;
            endcase
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_log(input int sel);
        int n_exp;
        logic [1:0] e_op [0:15];
        logic [7:0] e_dat [0:15];
        logic       e_nk [0:15];
        int eff;
        eff = present ? sel : 1;
        e_op[0] = 2'd0;
        e_op[1] = 2'd1; e_dat[1] = 8'hA0;
        if (eff == 1) begin
            e_op[2] = 2'd3; n_exp = 3;
        end else begin
            e_op[2] = 2'd1; e_dat[2] = 8'h00;
            if (eff == 2) begin
                e_op[3] = 2'd3; n_exp = 4;
            end else begin
                e_op[3] = 2'd0;
                e_op[4] = 2'd1; e_dat[4] = 8'hA1;
                if (eff == 3) begin
                    e_op[5] = 2'd3; n_exp = 6;
                end else begin
                    for (int k = 0; k < 8; k++) begin
                        e_op[5+k] = 2'd2;
                        e_nk[5+k] = (k == 7);
                    end
                    e_op[13] = 2'd3; n_exp = 14;
                end
            end
        end
        check((eff == 0) ? "R2 command count" : "R6 command count", nlog, n_exp);
        for (int k = 0; k < n_exp && k < nlog; k++) begin
            check((eff == 0) ? "R2 op order" : "R6 op order", lg_op[k], e_op[k]);
            if (e_op[k] == 2'd1) check("R2 write byte", lg_dat[k], e_dat[k]);
            if (e_op[k] == 2'd2) check("R3 read ack/nack", lg_nk[k], e_nk[k]);
        end
    endtask

    task automatic run_case(input int sel, input bit dev_on);
        logic exp_ok;
        bit   seen;
        present  = dev_on;
        nack_sel = sel;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 done in reset", load_done, 1'b0);
        check("R1 ok in reset", load_ok, 1'b0);
        check("R1 no cmd in reset", cmd_valid, 1'b0);
        check("R1 vid in reset", vendor_id, B_VID);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R7 not done early", load_done, 1'b0);
        check("R7 default pid early", product_id, B_PID);
        seen = 1'b0;
        for (int c = 0; c < 3000 && !seen; c++) begin
            @(negedge clk);
            if (load_done) seen = 1'b1;
        end
        check("R8 done rises", seen, 1'b1);
        repeat (5) @(negedge clk);
        check("R8 done stays", load_done, 1'b1);
        exp_ok = dev_on && (sel == 0) && (mem[7] == 8'h58);
        check("R5 load_ok", load_ok, exp_ok);
        check("R4 vendor_id", vendor_id,  exp_ok ? {mem[1], mem[0]} : B_VID);
        check("R4 product_id", product_id, exp_ok ? {mem[3], mem[2]} : B_PID);
        check("R4 cfg_attr", cfg_attr,   exp_ok ? mem[4] : B_ATTR);
        check("R4 max_power", max_power,  exp_ok ? mem[5] : B_PWR);
        check_log(sel);
    endtask

    initial begin
        for (int s = 0; s < 256; s++) begin
            for (int i = 0; i < 7; i++) mem[i] = 8'((s * 7) + (i * 29) + 3);
            mem[7] = 8'(s);
            run_case(0, 1'b1);
        end
        // R4: reserved byte 6 swept with the signature valid
        for (int p = 0; p < 8; p++) begin
            for (int i = 0; i < 6; i++) mem[i] = 8'((p * 53) + (i * 17) + 1);
            mem[6] = 8'(p * 37);
            mem[7] = 8'h58;
            run_case(0, 1'b1);
        end
        // R6: abort at each address phase and with no device
        mem[7] = 8'h58;
        run_case(1, 1'b1);
        run_case(2, 1'b1);
        run_case(3, 1'b1);
        run_case(0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 190000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule